// File: doc/BRIEF.md
# Time-of-Day Counter with Coherent Snapshot Readout

This block keeps a free-running time-of-day value and presents it through a small register port. The time value has two fields: a 30-bit nanoseconds field and a 48-bit seconds field. Every clock cycle the nanoseconds field advances by a fixed, parameterized amount. When it reaches one billion, it wraps, and the seconds field steps up by one.

Software reads the time in three words. Reading the nanoseconds word also copies the seconds field into a shadow register. The two seconds words are then served from that shadow. This way, a read sequence that starts with the nanoseconds word always yields one coherent 78-bit time, even when the counter rolls over between the reads.

Each seconds rollover raises an interrupt line. The line stays high until software writes to a dedicated clear word. The interrupt is governed by a two-state machine with these parts:
- State IRQ_IDLE: the line is low.
- State IRQ_PENDING: the line is high.
- Transition SET (IRQ_IDLE to IRQ_PENDING): taken on a rollover.
- Transition CLEAR (IRQ_PENDING to IRQ_IDLE): taken on a clear write with no rollover in the same cycle.
- Transition HOLD (IRQ_PENDING to IRQ_PENDING): taken when a rollover and a clear write happen in the same cycle.
- Transition WAIT (IRQ_IDLE to IRQ_IDLE): taken otherwise.

Top module: `rtc_snap_regs`

## Requirements
- R1: Reset sets all of the following to zero: the counter, the seconds shadow, the read data output and the interrupt line.
- R2: Each cycle out of reset, the nanoseconds field grows by NS_INC. When the sum is 1,000,000,000 or more, the field takes the sum minus 1,000,000,000, and the seconds field grows by one in the same cycle.
- R3: A read is presented on the clock edge where rd_en is sampled high, and rd_data holds the word from that edge until the next read. A read at address 0x14 returns the nanoseconds value loaded at that edge in bits 29:0, with bits 31:30 zero.
- R4: A read at 0x14 also loads the seconds value of that edge into the shadow. A read at 0x18 returns shadow bits 31:0. A read at 0x1C returns shadow bits 47:32 in bits 15:0, with bits 31:16 zero. Both return the shadow, not the live counter.
- R5: When a read at 0x14 falls on the edge where the seconds field rolls over, the shadow and the returned nanoseconds are both the post-rollover values.
- R6: The interrupt line rises on the same edge where the seconds field increments, and stays high until it is cleared.
- R7: A write of any data to 0x20 drops the interrupt line on that edge. A read at 0x20 returns zero.
- R8: When a rollover and a clear write happen on the same edge, the interrupt line stays high.
- R9: Writes to 0x14, 0x18 and 0x1C change nothing. Reads at any other address (for example 0x00, 0x10, 0x15, 0x24, 0xFF) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte offset of the register accessed |
| wr_data | input | 32 | Write data; its value is never used |
| rd_data | output | 32 | Registered read word |
| irq | output | 1 | Periodic interrupt, high while pending |

## Verification
The hardest situations to reach from the ports are those where an access lands exactly on the edge where the seconds field rolls over. There are two of them: a snapshot read that must store the post-rollover pair, and a clear write that must lose to the new set. The bench keeps its own time model and waits until that model predicts a rollover on the coming edge. It then issues the access at exactly that edge. The bench uses a large increment that does not divide one billion evenly. This makes rollovers occur every few cycles and leaves a nonzero nanoseconds remainder after each wrap.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
    localparam int unsigned NS_W       = 30;
    localparam int unsigned SEC_W      = 48;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam int unsigned SEC_HI_W   = SEC_W - DATA_W;

    localparam logic [ADDR_W-1:0] OFF_NS     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SEC_LO = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_SEC_HI = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h20;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } rtc_time_t;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;
endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_snap_pkg::*;
#(
    parameter int unsigned NS_INC = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    output rtc_time_t cur,
    output rtc_time_t nxt,
    output logic      tick
);
    localparam int unsigned SUM_W = NS_W + 1;
    localparam logic [SUM_W-1:0] INC_V  = SUM_W'(NS_INC);
    localparam logic [SUM_W-1:0] WRAP_V = SUM_W'(NS_PER_SEC);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = {1'b0, cur.ns} + INC_V;
        tick = (sum >= WRAP_V);
        nxt  = cur;
        if (tick) begin
            nxt.ns  = NS_W'(sum - WRAP_V);
            nxt.sec = cur.sec + 1'b1;
        end else begin
            nxt.ns  = sum[NS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/rtc_snap_shadow.sv
module rtc_snap_shadow
    import rtc_snap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEC_W-1:0] sec_in,
    output logic [SEC_W-1:0] sec_held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_held <= '0;
        end else if (capture) begin
            sec_held <= sec_in;
        end
    end
endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (set_evt) state_d = IRQ_PENDING;
            IRQ_PENDING: if (clr_evt && !set_evt) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_PENDING: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_snap_regs.sv
module rtc_snap_regs
    import rtc_snap_pkg::*;
#(
    parameter int unsigned NS_INC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    rtc_time_t        cur;
    rtc_time_t        nxt;
    logic             tick;
    logic [SEC_W-1:0] sec_held;
    logic [NS_W-1:0]  cur_ns;
    logic [SEC_W-1:0] cur_sec;
    logic             capture;
    logic             clr_evt;
    logic [DATA_W-1:0] rd_word;
    logic             wr_data_unused;

    assign wr_data_unused = ^wr_data;
    assign cur_ns  = cur.ns;
    assign cur_sec = cur.sec;
    assign capture = rd_en && (addr == OFF_NS);
    assign clr_evt = wr_en && (addr == OFF_CLR);

    rtc_tod_counter #(.NS_INC(NS_INC)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (cur),
        .nxt  (nxt),
        .tick (tick)
    );

    rtc_snap_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .sec_in  (nxt.sec),
        .sec_held(sec_held)
    );

    rtc_irq_fsm u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(tick),
        .clr_evt(clr_evt),
        .irq    (irq)
    );

    always_comb begin
        case (addr)
            OFF_NS:     rd_word = {{(DATA_W-NS_W){1'b0}}, nxt.ns};
            OFF_SEC_LO: rd_word = sec_held[DATA_W-1:0];
            OFF_SEC_HI: rd_word = {{(DATA_W-SEC_HI_W){1'b0}}, sec_held[SEC_W-1:DATA_W]};
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_word;
        end
    end
endmodule

// File: rtl/rtc_snap_checker.sv
module rtc_snap_checker
    import rtc_snap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [NS_W-1:0]   cur_ns,
    input logic [SEC_W-1:0]  cur_sec
);
    logic rd_unmapped;
    assign rd_unmapped = rd_en && addr != OFF_NS && addr != OFF_SEC_LO
                         && addr != OFF_SEC_HI;

    // R2
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ns < NS_W'(NS_PER_SEC));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sec != $past(cur_sec)) |-> (cur_ns < $past(cur_ns)));

    // R3
    ns_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == OFF_NS) |-> (rd_data[31:30] == 2'b00));

    // R4
    sec_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == OFF_SEC_HI) |-> (rd_data[31:16] == 16'h0));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cur_sec != $past(cur_sec)));

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && addr == OFF_CLR));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sec != $past(cur_sec)) |-> irq);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_unmapped) |-> (rd_data == '0));
endmodule

bind rtc_snap_regs rtc_snap_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .rd_data(rd_data),
    .irq    (irq),
    .cur_ns (cur_ns),
    .cur_sec(cur_sec)
);

// File: tb/rtc_snap_regs_bench.sv
`timescale 1ns/1ps
module rtc_snap_regs_bench;
    localparam int unsigned INC  = 70_000_000;
    localparam longint unsigned NSPS = 1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rtc_snap_regs #(.NS_INC(INC)) u_rtc_snap_regs (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Reference time model built from R2, R6, R7, R8
    longint unsigned m_ns = 0;
    logic [47:0] m_sec = '0;
    logic [47:0] m_shadow = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ns  <= 0;
            m_sec <= '0;
        end else if (m_ns + INC >= NSPS) begin
            m_ns  <= m_ns + INC - NSPS;
            m_sec <= m_sec + 1;
        end else begin
            m_ns  <= m_ns + INC;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [7:0] a;
        string      tag;
    } rd_item_t;
    rd_item_t q[$];

    // Driver: issue one read and queue its expectation
    task automatic do_read(input logic [7:0] a, input string tag);
        rd_en = 1'b1;
        addr  = a;
        q.push_back('{a, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Stay at a negedge after which the coming edge rolls the seconds
    task automatic wait_roll();
        while (m_ns + INC < NSPS) @(negedge clk);
    endtask

    // Monitor: pop and compare each read result
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && rst_n) begin
                rd_item_t it;
                logic [31:0] exp;
                it = q.pop_front();
                @(negedge clk);
                case (it.a)
                    8'h14: begin
                        exp = 32'(m_ns);
                        m_shadow = m_sec;
                    end
                    8'h18:   exp = m_shadow[31:0];
                    8'h1C:   exp = {16'h0, m_shadow[47:32]};
                    default: exp = 32'h0;
                endcase
                check(rd_data, exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data, 32'h0, "R1 rd_data in reset");
        check({31'h0, irq}, 32'h0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h18, "R1 shadow lo after reset");
        do_read(8'h1C, "R1 shadow hi after reset");

        // R2 / R3: back-to-back nanosecond reads across a wrap
        for (int i = 0; i < 18; i++) do_read(8'h14, "R2 R3 ns read");

        // R6: interrupt rises with the rollover
        wait_roll();
        @(negedge clk);
        check({31'h0, irq}, 32'h1, "R6 irq set on rollover");
        repeat (2) @(negedge clk);
        check({31'h0, irq}, 32'h1, "R6 irq held");

        // R7: clear with arbitrary data, read of clear word
        do_write(8'h20, 32'h5A5A_0000);
        check({31'h0, irq}, 32'h0, "R7 irq cleared");
        do_read(8'h20, "R7 clear word reads zero");

        // R4: seconds words come from the shadow, not the live counter
        do_read(8'h14, "R4 snapshot");
        repeat (40) @(negedge clk);
        do_read(8'h18, "R4 shadow lo stale");
        do_read(8'h1C, "R4 shadow hi");

        // R8: clear on the rollover edge loses
        wait_roll();
        do_write(8'h20, 32'hFFFF_FFFF);
        check({31'h0, irq}, 32'h1, "R8 set wins over clear");

        // R5: snapshot on the rollover edge
        wait_roll();
        do_read(8'h14, "R5 ns at rollover");
        do_read(8'h18, "R5 sec lo at rollover");
        wait_roll();
        do_read(8'h14, "R5 ns at rollover again");
        repeat (5) @(negedge clk);
        do_read(8'h18, "R5 sec lo second");

        // R9: writes to read-only words are ignored
        do_write(8'h14, 32'hFFFF_FFFF);
        do_write(8'h18, 32'hFFFF_FFFF);
        do_write(8'h1C, 32'hFFFF_FFFF);
        do_read(8'h18, "R9 shadow after ro write");
        do_read(8'h14, "R9 ns after ro write");
        do_read(8'h1C, "R9 sec hi after ro write");

        // R9: unmapped reads
        do_read(8'h00, "R9 unmapped 0x00");
        do_read(8'h10, "R9 unmapped 0x10");
        do_read(8'h15, "R9 unmapped 0x15");
        do_read(8'h24, "R9 unmapped 0x24");
        do_read(8'hFF, "R9 unmapped 0xFF");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule